// File: doc/BRIEF.md
# PLL Power-Up and Lock Retry Sequencer

This block brings an analog PLL out of power-down with a fixed, timed sequence. A start pulse makes it pulse a software reset, raise four power and enable bits one after another with a set wait after each, arm the lock detector by writing one code and then a second, and then sample a ready input a bounded number of times. If the first pass does not lock, it resets the PLL again and runs a recovery ladder. In that ladder the regulator enable drops out and comes back before the PLL is enabled. Then the lock-detect phase runs once more.

All waits are written in microseconds and counted as microseconds times `CLKS_PER_US` cycles of the block clock. The block reports the result through a one-cycle done pulse and a sticky locked or fail flag. A separate shutdown input removes power from the PLL at once, whatever the sequencer is doing.

Top module: `pll_powerup_seq`

## Requirements
- R1: After reset, sw_reset is 0, pwr_ctrl is 0, lkdet_code is 0x00, and seq_done, pll_locked and seq_fail are all 0.
- R2: On the clock edge that samples start while idle, sw_reset goes to 1 with pwr_ctrl at 0. It stays at 1 for 1 µs, then stays at 0 for 1 µs before the first power bit rises.
- R3: pwr_ctrl bit 0 is power-down-bar, bit 1 is power-generator enable, bit 2 is regulator (LDO) enable and bit 3 is PLL enable. On the first pass the bits rise in order 0, 1, 2, 3, and the waits after each step are 1, 200, 500 and 600 µs.
- R4: After the power ladder, lkdet_code is 0x0C for 100 µs and then becomes 0x0D.
- R5: ready is sampled one cycle after lkdet_code becomes 0x0D and then every 100 µs, at most 5 times. The first high sample sets pll_locked and pulses seq_done, and the sequence ends there.
- R6: ready has no effect between sampling edges.
- R7: If all 5 samples of the first pass are low, then 100 µs after the last sample the block re-runs the reset pulse of R2. It then runs the recovery ladder, with pwr_ctrl values 0x1, 0x3, 0x7, 0x3, 0x7, 0xF and waits of 1, 200, 250, 200, 500 and 600 µs. After that the lock-detect phase of R4 and R5 follows again.
- R8: If the second pass also sees no high sample, seq_fail sets and seq_done pulses 100 µs after its last sample. No further attempt follows, and the power bits stay at 0xF.
- R9: seq_done is high for exactly one cycle. When it is high, exactly one of pll_locked and seq_fail is set. Both flags hold until the next accepted start or a shutdown.
- R10: start has no effect while a sequence is running.
- R11: shutdown clears pwr_ctrl, sw_reset, pll_locked and seq_fail on the next edge and aborts any sequence. lkdet_code keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a power-up sequence (idle only) |
| shutdown | input | 1 | Remove all PLL power immediately |
| pll_ready | input | 1 | Lock indication from the PLL |
| sw_reset | output | 1 | PLL software reset |
| pwr_ctrl | output | 4 | {pll_en, ldo_en, pgen_en, pwrdn_b} |
| lkdet_code | output | 8 | Lock-detect setting |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |
| pll_locked | output | 1 | Sequence ended with lock |
| seq_fail | output | 1 | Sequence ended without lock |

## Verification
The bench compares every output on every cycle against a schedule built from the requirements. That catches an off-by-one wait, which would shift each later edge, and a swapped ladder step, which would show a wrong pwr_ctrl value. It places ready pulses on the first and last sampling edge and on a non-sampling cycle. A sampler that is late by a cycle or keeps ready high between samples would lock at the wrong time. Runs with no lock cover the recovery ladder and the final fail. A design that skipped the regulator off-and-on step, or retried a third time, would drift from the schedule. Shutdown is driven both mid-ladder and after lock, and a start is pulsed during a run, which a design that restarts on it would follow.

// File: rtl/pll_powerup_pkg.sv
package pll_powerup_pkg;

  localparam logic [3:0] STEP_BOOT    = 4'd0;
  localparam logic [3:0] STEP_RECOVER = 4'd6;
  localparam logic [3:0] STEP_LKDET   = 4'd14;
  localparam logic [7:0] LKDET_ARM    = 8'h0C;
  localparam logic [7:0] LKDET_RUN    = 8'h0D;

  typedef enum logic [1:0] {PH_IDLE, PH_STEP, PH_POLL} phase_e;

  // One entry of the sequence: outputs applied on entry, then a wait.
  typedef struct packed {
    logic       rst;
    logic [3:0] pwr;
    logic       code_wr;
    logic [7:0] code;
    logic [9:0] us;
    logic       poll;
    logic [3:0] nxt;
  } step_t;

  function automatic step_t mk(input logic rst, input logic [3:0] pwr,
                               input logic code_wr, input logic [7:0] code,
                               input logic [9:0] us, input logic poll,
                               input logic [3:0] nxt);
    step_t s;
    s.rst = rst; s.pwr = pwr; s.code_wr = code_wr; s.code = code;
    s.us = us; s.poll = poll; s.nxt = nxt;
    return s;
  endfunction

  // Steps 0..5 first ladder, 6..13 recovery ladder, 14..15 lock-detect arm.
  function automatic step_t step_at(input logic [3:0] i);
    case (i)
      4'd0:    return mk(1'b1, 4'h0, 1'b0, 8'h00, 10'd1,   1'b0, 4'd1);
      4'd1:    return mk(1'b0, 4'h0, 1'b0, 8'h00, 10'd1,   1'b0, 4'd2);
      4'd2:    return mk(1'b0, 4'h1, 1'b0, 8'h00, 10'd1,   1'b0, 4'd3);
      4'd3:    return mk(1'b0, 4'h3, 1'b0, 8'h00, 10'd200, 1'b0, 4'd4);
      4'd4:    return mk(1'b0, 4'h7, 1'b0, 8'h00, 10'd500, 1'b0, 4'd5);
      4'd5:    return mk(1'b0, 4'hF, 1'b0, 8'h00, 10'd600, 1'b0, STEP_LKDET);
      4'd6:    return mk(1'b1, 4'h0, 1'b0, 8'h00, 10'd1,   1'b0, 4'd7);
      4'd7:    return mk(1'b0, 4'h0, 1'b0, 8'h00, 10'd1,   1'b0, 4'd8);
      4'd8:    return mk(1'b0, 4'h1, 1'b0, 8'h00, 10'd1,   1'b0, 4'd9);
      4'd9:    return mk(1'b0, 4'h3, 1'b0, 8'h00, 10'd200, 1'b0, 4'd10);
      4'd10:   return mk(1'b0, 4'h7, 1'b0, 8'h00, 10'd250, 1'b0, 4'd11);
      4'd11:   return mk(1'b0, 4'h3, 1'b0, 8'h00, 10'd200, 1'b0, 4'd12);
      4'd12:   return mk(1'b0, 4'h7, 1'b0, 8'h00, 10'd500, 1'b0, 4'd13);
      4'd13:   return mk(1'b0, 4'hF, 1'b0, 8'h00, 10'd600, 1'b0, STEP_LKDET);
      4'd14:   return mk(1'b0, 4'hF, 1'b1, LKDET_ARM, 10'd100, 1'b0, 4'd15);
      default: return mk(1'b0, 4'hF, 1'b1, LKDET_RUN, 10'd0, 1'b1, 4'd15);
    endcase
  endfunction

  function automatic int unsigned us_to_cycles(input logic [9:0] us,
                                               input int unsigned cpu);
    return int'(us) * cpu;
  endfunction

endpackage

// File: rtl/pll_powerup_seq_steps.sv
module pll_powerup_seq_steps
  import pll_powerup_pkg::*;
#(
  parameter int CLKS_PER_US = 100,
  parameter int CW          = 16
) (
  input  logic [3:0]    idx,
  output logic          rst,
  output logic [3:0]    pwr,
  output logic          code_wr,
  output logic [7:0]    code,
  output logic          poll,
  output logic [3:0]    nxt,
  output logic [CW-1:0] cycles
);
  step_t s;
  always_comb begin
    s       = step_at(idx);
    rst     = s.rst;
    pwr     = s.pwr;
    code_wr = s.code_wr;
    code    = s.code;
    poll    = s.poll;
    nxt     = s.nxt;
    cycles  = CW'(us_to_cycles(s.us, CLKS_PER_US));
  end
endmodule

// File: rtl/pll_powerup_seq_timer.sv
module pll_powerup_seq_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end
  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pll_powerup_seq.sv
module pll_powerup_seq
  import pll_powerup_pkg::*;
#(
  parameter int CLKS_PER_US = 100,
  parameter int POLL_COUNT  = 5,
  parameter int POLL_GAP_US = 100,
  parameter int ATTEMPTS    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       shutdown,
  input  logic       pll_ready,
  output logic       sw_reset,
  output logic [3:0] pwr_ctrl,
  output logic [7:0] lkdet_code,
  output logic       seq_done,
  output logic       pll_locked,
  output logic       seq_fail
);
  localparam int MAX_US = (POLL_GAP_US > 600) ? POLL_GAP_US : 600;
  localparam int CW     = $clog2(MAX_US * CLKS_PER_US + 1);
  localparam int TW     = $clog2(POLL_COUNT + 1);
  localparam int AW     = $clog2(ATTEMPTS + 1);
  localparam logic [CW-1:0] GAP_LOAD = CW'(POLL_GAP_US * CLKS_PER_US - 1);

  phase_e        phase_q;
  logic [3:0]    nxt_q;
  logic [TW-1:0] tries_q;
  logic [AW-1:0] attempt_q;
  logic          rst_q, done_q, locked_q, fail_q;
  logic [3:0]    pwr_q;
  logic [7:0]    code_q;

  // Named events, also watched by the bound checker.
  logic          boot, advance, poll_tick, poll_over, poll_sample;
  logic          lock_seen, give_up, retry, step_enter;
  logic [3:0]    tgt;
  logic          tmr_load, tmr_exp;
  logic [CW-1:0] tmr_val;

  logic          t_rst, t_code_wr, t_poll;
  logic [3:0]    t_pwr, t_nxt;
  logic [7:0]    t_code;
  logic [CW-1:0] t_cycles;

  pll_powerup_seq_steps #(.CLKS_PER_US(CLKS_PER_US), .CW(CW)) u_steps (
    .idx(tgt), .rst(t_rst), .pwr(t_pwr), .code_wr(t_code_wr), .code(t_code),
    .poll(t_poll), .nxt(t_nxt), .cycles(t_cycles)
  );

  pll_powerup_seq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_exp)
  );

  always_comb begin
    boot        = (phase_q == PH_IDLE) && start;
    advance     = (phase_q == PH_STEP) && tmr_exp;
    poll_tick   = (phase_q == PH_POLL) && tmr_exp;
    poll_over   = poll_tick && (tries_q == TW'(POLL_COUNT));
    poll_sample = poll_tick && !poll_over;
    lock_seen   = poll_sample && pll_ready;
    give_up     = poll_over && (attempt_q == AW'(ATTEMPTS - 1));
    retry       = poll_over && !give_up;
    step_enter  = !shutdown && (boot || advance || retry);
    tgt         = boot ? STEP_BOOT : (retry ? STEP_RECOVER : nxt_q);
    tmr_load    = step_enter || (poll_sample && !pll_ready && !shutdown);
    if (step_enter) tmr_val = t_poll ? '0 : (t_cycles - CW'(1));
    else            tmr_val = GAP_LOAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      nxt_q     <= STEP_BOOT;
      tries_q   <= '0;
      attempt_q <= '0;
      rst_q     <= 1'b0;
      pwr_q     <= '0;
      code_q    <= '0;
      done_q    <= 1'b0;
      locked_q  <= 1'b0;
      fail_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (shutdown) begin
        phase_q  <= PH_IDLE;
        rst_q    <= 1'b0;
        pwr_q    <= '0;
        locked_q <= 1'b0;
        fail_q   <= 1'b0;
      end else begin
        if (step_enter) begin
          rst_q   <= t_rst;
          pwr_q   <= t_pwr;
          nxt_q   <= t_nxt;
          tries_q <= '0;
          phase_q <= t_poll ? PH_POLL : PH_STEP;
          if (t_code_wr) code_q <= t_code;
        end
        if (boot) begin
          attempt_q <= '0;
          locked_q  <= 1'b0;
          fail_q    <= 1'b0;
        end
        if (retry) attempt_q <= attempt_q + AW'(1);
        if (poll_sample && !pll_ready) tries_q <= tries_q + TW'(1);
        if (lock_seen) begin
          locked_q <= 1'b1;
          done_q   <= 1'b1;
          phase_q  <= PH_IDLE;
        end
        if (give_up) begin
          fail_q  <= 1'b1;
          done_q  <= 1'b1;
          phase_q <= PH_IDLE;
        end
      end
    end
  end

  assign sw_reset   = rst_q;
  assign pwr_ctrl   = pwr_q;
  assign lkdet_code = code_q;
  assign seq_done   = done_q;
  assign pll_locked = locked_q;
  assign seq_fail   = fail_q;

endmodule

// File: rtl/pll_powerup_seq_sva.sv
module pll_powerup_seq_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       shutdown,
  input logic       sw_reset,
  input logic [3:0] pwr_ctrl,
  input logic       seq_done,
  input logic       pll_locked,
  input logic       seq_fail,
  input logic       step_enter,
  input logic       lock_seen,
  input logic       give_up
);
  assert_reset_keeps_power_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |-> (pwr_ctrl == 4'h0));

  assert_pll_en_needs_lower_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_ctrl[3] |-> (pwr_ctrl[2:0] == 3'b111));

  assert_pgen_needs_pwrdn_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_ctrl[1] |-> pwr_ctrl[0]);

  assert_power_moves_on_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_enter && !shutdown) |=> $stable(pwr_ctrl));

  assert_lock_reported_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_seen && !shutdown) |=> (pll_locked && seq_done));

  assert_fail_reported_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (give_up && !shutdown) |=> (seq_fail && seq_done));

  assert_done_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  assert_done_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (pll_locked ^ seq_fail));

  assert_shutdown_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (pwr_ctrl == 4'h0 && !sw_reset && !pll_locked && !seq_fail));
endmodule

bind pll_powerup_seq pll_powerup_seq_sva u_sva (
  .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .sw_reset(sw_reset),
  .pwr_ctrl(pwr_ctrl), .seq_done(seq_done), .pll_locked(pll_locked),
  .seq_fail(seq_fail), .step_enter(step_enter), .lock_seen(lock_seen),
  .give_up(give_up)
);

// File: tb/pll_powerup_seq_test.sv
module pll_powerup_seq_test;
  localparam int CPU = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, shutdown = 1'b0, pll_ready = 1'b0;
  logic sw_reset, seq_done, pll_locked, seq_fail;
  logic [3:0] pwr_ctrl;
  logic [7:0] lkdet_code;

  always #2 clk = ~clk;

  pll_powerup_seq #(.CLKS_PER_US(CPU)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .shutdown(shutdown),
    .pll_ready(pll_ready), .sw_reset(sw_reset), .pwr_ctrl(pwr_ctrl),
    .lkdet_code(lkdet_code), .seq_done(seq_done), .pll_locked(pll_locked),
    .seq_fail(seq_fail)
  );

  typedef struct {
    int at; logic rs; logic [3:0] pw; logic [7:0] cd;
    logic dn; logic lk; logic fl; logic [23:0] tg;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int checks = 0, fails = 0, prints = 0;
  int t, tend, ts, td, tdf, r0, r1, r2;
  logic [7:0] code_now = 8'h00;
  logic arm = 1'b0, act = 1'b0, fin = 1'b0, over = 1'b0;

  task automatic report(input logic [23:0] tg, input string what,
                        input int act_v, input int exp_v);
    fails++;
    if (prints < 30) begin
      prints++;
      $display("FAIL %s t=%0d %s actual=%0h expected=%0h", tg, t, what, act_v, exp_v);
    end
  endtask

  task automatic add(input int at, input logic rs, input logic [3:0] pw,
                     input logic [7:0] cd, input logic dn, input logic lk,
                     input logic fl, input logic [23:0] tg);
    exp_t e;
    if (tdf >= 0 && at >= tdf) return;
    e.at = at; e.rs = rs; e.pw = pw; e.cd = cd; e.dn = dn; e.lk = lk;
    e.fl = fl; e.tg = tg;
    q.push_back(e);
    code_now = cd;
  endtask

  // Driver: builds the expected schedule from the requirements, then arms.
  // lk0/lk1: sample index that sees ready per pass (-1 none); tdin: shutdown
  // time (-1 none, -2 shortly after the last event); ts_in: extra start pulse;
  // spur: ready pulse offset from the first sample of pass 0 (-1 none).
  task automatic run(input int lk0, input int lk1, input int tdin,
                     input int ts_in, input int spur);
    int T, tk, lk, s0;
    int us0[4]   = '{1, 200, 500, 600};
    logic [3:0] pw0[4] = '{4'h1, 4'h3, 4'h7, 4'hF};
    int us1[6]   = '{1, 200, 250, 200, 500, 600};
    logic [3:0] pw1[6] = '{4'h1, 4'h3, 4'h7, 4'h3, 4'h7, 4'hF};
    q.delete();
    T = 0; s0 = 0; r0 = -1; r1 = -1; r2 = -1; ts = ts_in; tend = 0;
    tdf = (tdin >= 0) ? tdin : -1;
    for (int a = 0; a < 2; a++) begin
      add(T, 1'b1, 4'h0, code_now, 1'b0, 1'b0, 1'b0, "R2"); T += CPU;
      add(T, 1'b0, 4'h0, code_now, 1'b0, 1'b0, 1'b0, "R2"); T += CPU;
      if (a == 0) begin
        for (int i = 0; i < 4; i++) begin
          add(T, 1'b0, pw0[i], code_now, 1'b0, 1'b0, 1'b0, "R3"); T += us0[i] * CPU;
        end
      end else begin
        for (int i = 0; i < 6; i++) begin
          add(T, 1'b0, pw1[i], code_now, 1'b0, 1'b0, 1'b0, "R7"); T += us1[i] * CPU;
        end
      end
      add(T, 1'b0, 4'hF, 8'h0C, 1'b0, 1'b0, 1'b0, "R4"); T += 100 * CPU;
      add(T, 1'b0, 4'hF, 8'h0D, 1'b0, 1'b0, 1'b0, "R4"); T += 1;
      if (a == 0) s0 = T;
      lk = (a == 0) ? lk0 : lk1;
      if (lk >= 0) begin
        tk = T + lk * 100 * CPU;
        add(tk, 1'b0, 4'hF, 8'h0D, 1'b1, 1'b1, 1'b0, "R5");
        if (a == 0) r0 = tk; else r1 = tk;
        tend = tk + 10;
        break;
      end
      T += 5 * 100 * CPU;
      if (a == 1) begin
        add(T, 1'b0, 4'hF, 8'h0D, 1'b1, 1'b0, 1'b1, "R8");
        tend = T + 10;
      end
    end
    if (spur >= 0) r2 = s0 + spur;
    td = tdin;
    if (tdin == -2) td = q[q.size() - 1].at + 5;
    if (td >= 0) begin
      tdf = -1;
      add(td, 1'b0, 4'h0, code_now, 1'b0, 1'b0, 1'b0, "R11");
      tend = td + 10;
    end
    @(posedge clk); #1;
    fin = 1'b0; arm = 1'b1;
    wait (fin);
    checks++;
    if (q.size() != 0) report("R5", "unconsumed events", q.size(), 0);
  endtask

  // Monitor: drives the timed inputs and compares every cycle.
  always @(negedge clk) begin
    if (arm) begin
      arm = 1'b0; act = 1'b1; t = -1; start = 1'b1;
    end else if (act) begin
      t++;
      start = (t == ts);
      if (q.size() > 0 && q[0].at == t) cur = q.pop_front();
      checks++;
      if (sw_reset !== cur.rs) report(cur.tg, "sw_reset", sw_reset, cur.rs);
      if (pwr_ctrl !== cur.pw) report(cur.tg, "pwr_ctrl", pwr_ctrl, cur.pw);
      if (lkdet_code !== cur.cd) report(cur.tg, "lkdet_code", lkdet_code, cur.cd);
      if (seq_done !== (cur.dn && cur.at == t)) report("R9", "seq_done", seq_done, cur.dn && cur.at == t);
      if (pll_locked !== cur.lk) report(cur.tg, "pll_locked", pll_locked, cur.lk);
      if (seq_fail !== cur.fl) report(cur.tg, "seq_fail", seq_fail, cur.fl);
      pll_ready = (t + 1 == r0) || (t + 1 == r1) || (t + 1 == r2);
      shutdown  = (t + 1 == td);
      if (t >= tend) begin
        act = 1'b0; fin = 1'b1; start = 1'b0; pll_ready = 1'b0; shutdown = 1'b0;
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!over) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    cur = '{at: 0, rs: 1'b0, pw: 4'h0, cd: 8'h00, dn: 1'b0, lk: 1'b0, fl: 1'b0, tg: "R1"};
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks += 6;
    if (sw_reset !== 1'b0)    report("R1", "sw_reset", sw_reset, 0);
    if (pwr_ctrl !== 4'h0)    report("R1", "pwr_ctrl", pwr_ctrl, 0);
    if (lkdet_code !== 8'h00) report("R1", "lkdet_code", lkdet_code, 0);
    if (seq_done !== 1'b0)    report("R1", "seq_done", seq_done, 0);
    if (pll_locked !== 1'b0)  report("R1", "pll_locked", pll_locked, 0);
    if (seq_fail !== 1'b0)    report("R1", "seq_fail", seq_fail, 0);
    // R5: lock on the first sample
    run(0, -1, -1, -1, -1);
    // R6 and R10: ready pulse between samples, start pulse mid-ladder; lock on sample 2
    run(2, -1, -1, 100, 207);
    // R7: no lock in pass 0, lock on the last sample of the recovery pass
    run(-1, 4, -1, -1, -1);
    // R8: no lock at all, fail
    run(-1, -1, -1, -1, -1);
    // R11: shutdown after a lock
    run(1, -1, -2, -1, -1);
    // R11: shutdown in the middle of the ladder, code kept
    run(-1, -1, 500, -1, -1);
    // R2: a fresh start after an abort runs normally
    run(3, -1, -1, -1, -1);
    over = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule